// File: doc/BRIEF.md
# Eight-Times Half-Band Interpolator

This block raises the sample rate of a signed 24-bit PCM stream by a factor of eight. It is built from three identical 2x stages in series. Each stage behaves as if one zero were placed between consecutive input samples and the result passed through a symmetric half-band low-pass FIR. The first stage has the steepest filter, with 23 taps. The two later stages only have to reject images that sit farther from the passband, so they use 11 taps each.

No zero is ever stored or multiplied. The centre tap is exactly one half, and the factor of two in interpolation gain cancels it, so each stage emits the delayed input sample unchanged as its first phase. The second phase is a sum over pre-added symmetric pairs that uses only the non-zero side taps. Rounding (half up) and saturation to 24 bits happen at each stage output.

Samples enter through a valid/ready handshake at the base rate and leave through a valid/ready handshake at eight times that rate. Backpressure propagates stage by stage.

Top module: `hbi_interp8_top`

## Requirements
- R1: Every input accepted (in_valid and in_ready high at a rising clock edge) produces exactly eight output transfers (out_valid and out_ready high at an edge), delivered in order. Every stage produces two outputs per input, and an accepted input raises the stage's output valid in the next cycle.
- R2: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change in the next cycle.
- R3: A stage raises its input ready only when it holds no sample, or while the second of its two outputs is being taken. After an input is accepted, in_ready is low in the next cycle. With out_ready held low from reset, exactly one input is accepted.
- R4: For each input x[n], a stage with half-length M emits x[n-M] unchanged first. Second it emits the interpolated value between x[n-M] and x[n-M+1]. At the top level, a single impulse at input index 0 reappears unchanged at output index 66.
- R5: The second phase uses unique side coefficients c_k, k=0..M-1, in 18-bit Q1.17, where c_0 is the tap nearest the centre. For the first stage (M=6) these are 40500, -10800, 4900, -2300, 900, -432. For the two later stages (M=3) they are 38600, -7000, 1168. Each list sums to 32768.
- R6: The second phase equals floor((S + 2^15) / 2^16). Here S = sum over k of c_k * (w[M-1-k] + w[M+k]), and w[0] is the newest input in the window.
- R7: Every stage output is saturated to the range -8388608 to 8388607.
- R8: rst_n is asynchronous and active low, and its release is synchronised over two clock edges. Reset clears all delay lines and all stage phases. After release, out_valid is 0 and in_ready is 1.
- R9: After reset, an all-zero input stream produces only zero outputs.
- R10: A constant input settles to exactly the same constant at the output (DC gain of one).
- R11: The output sequence for any input stream equals the three-stage cascade of R4 to R7 applied bit-exactly, starting from zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | 24 | Signed output sample at eight times the input rate |

## Verification
The assertions check the handshake rules on every cycle inside each stage: output is held under stall, every acceptance yields output in the next cycle, the second phase always follows the first, and ready drops after acceptance. They also check the idle state right after reset. The arithmetic can only be shown by the bench's scenarios: rounding, saturation, coefficient values, the impulse position, DC gain and the zero-input case. In those scenarios, a behavioural cascade model predicts every output sample, including under random gaps and backpressure. The single-acceptance limit under a permanent stall is also a scenario check.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EVEN = 2'd1,
    PH_ODD  = 2'd2
  } hb_phase_e;

  // Unique side taps in Q1.17, nearest-to-centre first; each set sums to 2^15.
  function automatic int hb_coef(input int half_m, input int k);
    int c;
    c = 0;
    if (half_m == 6) begin
      case (k)
        0: c = 40500;
        1: c = -10800;
        2: c = 4900;
        3: c = -2300;
        4: c = 900;
        5: c = -432;
        default: c = 0;
      endcase
    end else if (half_m == 3) begin
      case (k)
        0: c = 38600;
        1: c = -7000;
        2: c = 1168;
        default: c = 0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 24,
  parameter int SHIFT = 16
) (
  input  logic signed [IN_W-1:0]  acc,
  output logic signed [OUT_W-1:0] q
);
  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] RND  = EXT_W'(1) << (SHIFT - 1);
  localparam logic signed [EXT_W-1:0] MAXV = {{(IN_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MINV = {{(IN_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] shifted;

  always_comb begin
    biased  = EXT_W'(acc) + RND;
    shifted = biased >>> SHIFT;
    if (shifted > MAXV) begin
      q = MAXV[OUT_W-1:0];
    end else if (shifted < MINV) begin
      q = MINV[OUT_W-1:0];
    end else begin
      q = shifted[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
  import hbi_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 18,
  parameter int HALF_M = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int WIN    = 2 * HALF_M;
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(HALF_M) + 1;
  localparam int SHIFT  = COEF_W - 2;

  hb_phase_e               phase_q, phase_d;
  logic signed [DATA_W-1:0] win_q [WIN];
  logic signed [DATA_W-1:0] win_d [WIN];
  logic signed [PRE_W-1:0]  pre   [HALF_M];
  logic signed [PROD_W-1:0] prod  [HALF_M];
  logic signed [ACC_W-1:0]  acc;
  logic signed [DATA_W-1:0] odd_val;
  logic                     accept;

  // handshake and phase sequencing
  always_comb begin
    in_ready = (phase_q == PH_IDLE) || ((phase_q == PH_ODD) && out_ready);
    accept   = in_valid && in_ready;
    phase_d  = phase_q;
    case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_EVEN;
      PH_EVEN: if (out_ready) phase_d = PH_ODD;
      PH_ODD:  if (out_ready) phase_d = accept ? PH_EVEN : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // window shift: newest sample at index 0
  generate
    for (genvar i = 0; i < WIN; i++) begin : g_shift
      if (i == 0) begin : g_head
        assign win_d[i] = in_data;
      end else begin : g_body
        assign win_d[i] = win_q[i-1];
      end
    end
  endgenerate

  // symmetric pre-add and multiply over the non-zero side taps only
  generate
    for (genvar k = 0; k < HALF_M; k++) begin : g_tap
      localparam logic signed [COEF_W-1:0] CK = COEF_W'(hb_coef(HALF_M, k));
      assign pre[k]  = PRE_W'(win_q[HALF_M-1-k]) + PRE_W'(win_q[HALF_M+k]);
      assign prod[k] = PROD_W'(pre[k]) * PROD_W'(CK);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < HALF_M; k++) begin
      acc = acc + ACC_W'(prod[k]);
    end
  end

  hbi_round_sat #(
    .IN_W (ACC_W),
    .OUT_W(DATA_W),
    .SHIFT(SHIFT)
  ) u_rnd (
    .acc(acc),
    .q  (odd_val)
  );

  always_comb begin
    out_valid = (phase_q != PH_IDLE);
    out_data  = (phase_q == PH_ODD) ? odd_val : win_q[HALF_M];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= win_d[i];
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R2
  AST_ACCEPT_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_SECOND_PHASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (phase_q == PH_EVEN) |=> out_valid); // R1
  AST_READY_DROPS_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R3

endmodule

// File: rtl/hbi_interp8_top.sv
module hbi_interp8_top #(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 18,
  parameter int N_STAGES = 3,
  parameter int M_FIRST  = 6,
  parameter int M_LATER  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  logic [1:0]               rst_sync_q;
  logic                     rst_sync_n;
  logic [N_STAGES:0]        lnk_vld;
  logic [N_STAGES:0]        lnk_rdy;
  logic signed [DATA_W-1:0] lnk_dat [N_STAGES+1];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign lnk_vld[0]        = in_valid;
  assign lnk_dat[0]        = in_data;
  assign in_ready          = lnk_rdy[0];
  assign lnk_rdy[N_STAGES] = out_ready;
  assign out_valid         = lnk_vld[N_STAGES];
  assign out_data          = lnk_dat[N_STAGES];

  generate
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      localparam int HM = (s == 0) ? M_FIRST : M_LATER;
      hbi_stage #(
        .DATA_W(DATA_W),
        .COEF_W(COEF_W),
        .HALF_M(HM)
      ) u_stage (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .in_valid (lnk_vld[s]),
        .in_ready (lnk_rdy[s]),
        .in_data  (lnk_dat[s]),
        .out_valid(lnk_vld[s+1]),
        .out_ready(lnk_rdy[s+1]),
        .out_data (lnk_dat[s+1])
      );
    end
  endgenerate

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !out_valid && in_ready); // R8

endmodule

// File: tb/hbi_interp8_top_tb_top.sv
`timescale 1ns/1ps
module hbi_interp8_top_tb_top;
  localparam int DW   = 24;
  localparam int SMAX = 8388607;
  localparam int SMIN = -8388608;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic signed [DW-1:0] in_data;
  logic                 out_valid;
  logic                 out_ready;
  logic signed [DW-1:0] out_data;

  int checks;
  int failures;
  int in_q[$];
  int exp_q[$];
  int got_q[$];

  hbi_interp8_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int tb_coef(input int m, input int k);
    int six[6]   = '{40500, -10800, 4900, -2300, 900, -432};
    int three[3] = '{38600, -7000, 1168};
    return (m == 6) ? six[k] : three[k];
  endfunction

  // behavioural 2x stage: centre sample, then rounded and saturated pair sum
  function automatic void ref_stage(input int m, ref int src[$], ref int dst[$]);
    int w[12];
    longint s;
    longint r;
    dst.delete();
    for (int i = 0; i < 12; i++) w[i] = 0;
    foreach (src[n]) begin
      for (int i = 11; i > 0; i--) w[i] = w[i-1];
      w[0] = src[n];
      dst.push_back(w[m]);
      s = 0;
      for (int k = 0; k < m; k++)
        s += longint'(tb_coef(m, k)) * (longint'(w[m-1-k]) + longint'(w[m+k]));
      r = (s + 64'sd32768) >>> 16;
      if (r > SMAX) r = SMAX;
      if (r < SMIN) r = SMIN;
      dst.push_back(int'(r));
    end
  endfunction

  function automatic void ref_cascade();
    int a[$];
    int b[$];
    ref_stage(6, in_q, a);
    ref_stage(3, a, b);
    ref_stage(3, b, exp_q);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // stream in_q through the block with random gaps and stalls
  task automatic play(input string tag, input int gap_pct, input int stall_pct);
    int ii = 0;
    int oo = 0;
    int cyc = 0;
    ref_cascade();
    got_q.delete();
    while (oo < exp_q.size() && cyc < 30000) begin
      @(negedge clk);
      in_valid  = (ii < in_q.size()) && ($urandom_range(99) >= gap_pct);
      in_data   = (ii < in_q.size()) ? DW'(in_q[ii]) : '0;
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        check(tag, int'(out_data), exp_q[oo]);
        got_q.push_back(int'(out_data));
        oo++;
      end
      cyc++;
    end
    check({tag, " output count"}, oo, exp_q.size());
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic run_all();
    int acc_cnt;
    int held;
    // R8 reset state
    do_reset();
    #1;
    check("R8 out_valid after reset", int'(out_valid), 0);
    check("R8 in_ready after reset", int'(in_ready), 1);

    // R9 zero stream
    in_q.delete();
    for (int i = 0; i < 20; i++) in_q.push_back(0);
    play("R9 zero", 10, 10);
    foreach (got_q[i]) check("R9 zero out", got_q[i], 0);

    // R4/R11 impulse
    do_reset();
    in_q.delete();
    in_q.push_back(1 << 20);
    for (int i = 0; i < 23; i++) in_q.push_back(0);
    play("R11 impulse", 0, 0);
    check("R4 impulse centre at 66", got_q[66], 1 << 20);
    check("R4 before centre", got_q[65] == (1 << 20) ? 1 : 0, 0);

    // R10 DC
    do_reset();
    in_q.delete();
    for (int i = 0; i < 30; i++) in_q.push_back(-1234567);
    play("R10 dc", 20, 30);
    for (int i = 130; i < 240; i++) check("R10 dc settled", got_q[i], -1234567);

    // R7 saturation: full-scale square wave
    do_reset();
    in_q.delete();
    for (int i = 0; i < 32; i++) in_q.push_back(((i / 4) % 2 == 0) ? SMAX : SMIN);
    play("R7 saturate", 0, 0);

    // R5/R6/R1 random stream with gaps and backpressure
    do_reset();
    in_q.delete();
    for (int i = 0; i < 60; i++) in_q.push_back(int'($urandom_range(2000000)) - 1000000);
    play("R6 random", 30, 40);

    // R1 ordering at full rate
    do_reset();
    in_q.delete();
    for (int i = 0; i < 40; i++) in_q.push_back((i * 97531) % 4000000 - 2000000);
    play("R1 full rate", 0, 0);

    // R3 and R2: permanent stall
    do_reset();
    acc_cnt = 0;
    held = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(555555); out_ready = 1'b0;
      #1;
      if (in_valid && in_ready) acc_cnt++;
      if (c == 10) held = int'(out_data);
    end
    #1;
    check("R3 single accept under stall", acc_cnt, 1);
    check("R2 valid held", int'(out_valid), 1);
    check("R2 data held", int'(out_data), held);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule